// File: doc/BRIEF.md
# Monitor Register Access Trap Router

This block decides what happens to a coprocessor-style read or write aimed at a bank of sixteen event-type registers that describe the activity-monitor counters. It checks the access encoding. It forms a register index from the encoding. It then runs a priority chain of enable and trap bits that depends on the current privilege level, from 0 to 3. The result is one of three outcomes: the register contents are returned, the access is reported as an undefined instruction, or a trap is raised. A trap names the privilege level that must handle it and carries a fixed syndrome code.

The event-type contents are constants. Each of the first four registers holds a fixed event number, so writes never change anything. Indices at or above the configured number of architected counters read as zero. Such an index raises no fault of its own.

The decision is combinational from the request fields. The response is registered and appears exactly one clock after the request strobe. The exception-entry logic of the core consumes this response.

Top module: `mon_acc_router`

## Requirements
- R1: An access is accepted only when coproc = 4'hF, opc1 = 3'b000, crn = 4'hD and crm[3:1] = 3'b011. Any other encoding gives rsp_undef = 1, rsp_trap = 0 and rsp_rdata = 0, whatever the level or the control bits.
- R2: On an accepted, untrapped read, the index is {crm[0], opc2[2:0]}. The returned data is then 32'h0000_0011 for index 0, 32'h0000_4004 for index 1, 32'h0000_0008 for index 2 and 32'h0000_4005 for index 3. Bits [31:16] are always zero.
- R3: An index at or above ARCH_CNT (default 4) reads as zero and raises neither a trap nor an undefined response. The permission checks still apply to it.
- R4: At level 0 with user_en = 0, the access traps. The target is level 2 when l2_en = 1 and l2_tge = 1, and level 1 otherwise.
- R5: At level 0 (once user_en = 1) and at level 1, the checks run in this order, and the first one that hits decides the trap: l2_cp13_trap, which sends to level 2 and counts only when l2_en = 1; then l2_mon_trap, which sends to level 2 and counts only when l2_en = 1; then l3_mon_trap, which sends to level 3 and counts only when l3_present = 1.
- R6: At level 0 only, l2_cp13_trap is ignored when l2_en, l2_host and l2_tge are all 1. At level 1 it is never ignored.
- R7: At level 2, the access traps to level 3 only when l3_present = 1 and l3_mon_trap = 1; otherwise the data is returned. At level 3, the access never traps.
- R8: rsp_syndrome is 6'h03 on every trap and 6'h00 on every response without a trap.
- R9: rsp_trap and rsp_undef are never both 1. A trapped response carries rsp_rdata = 0.
- R10: A write (req_write = 1) returns rsp_rdata = 0 and changes no register. It is subject to the same undefined and trap decisions as a read, and a later read of the same index returns the unchanged event number.
- R11: rsp_valid is 1 exactly one clock after a cycle with req_valid = 1. While rst is high, and on the first edge after it, all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_coproc | input | 4 | Coprocessor number field |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_opc2 | input | 3 | Second opcode field |
| cur_level | input | 2 | Current privilege level, 0 to 3 |
| user_en | input | 1 | Level-0 access enable |
| l2_en | input | 1 | Level 2 is enabled |
| l2_tge | input | 1 | Level-2 trap-general control |
| l2_host | input | 1 | Level-2 host-mode control |
| l2_cp13_trap | input | 1 | Level-2 trap on coprocessor-13 accesses |
| l2_mon_trap | input | 1 | Level-2 trap on monitor accesses |
| l3_present | input | 1 | Level 3 exists |
| l3_mon_trap | input | 1 | Level-3 trap on monitor accesses |
| rsp_valid | output | 1 | Response valid, one clock after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_trap | output | 1 | The access traps |
| rsp_trap_level | output | 2 | Level that takes the trap |
| rsp_syndrome | output | 6 | Syndrome code of the trap |
| rsp_undef | output | 1 | Encoding is not recognised |

## Verification
A bad encoding and a trapping control state can occur in the same request, because every trap bit is evaluated from the level and the control inputs regardless of the encoding. The bench provokes this by sending bad encodings while level 0 has user_en cleared and all the other trap bits are set. It expects only the undefined response, with no trap and zero data. A second overlap is an out-of-range index or a write together with a trapping state. Here the trap must win and the data must stay zero. The bench covers this with directed requests and with random requests, each judged against a behavioural model on every clock.

// File: rtl/mon_acc_pkg.sv
package mon_acc_pkg;

    typedef enum logic [1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } lvl_e;

    typedef struct packed {
        logic user_en;
        logic l2_en;
        logic l2_tge;
        logic l2_host;
        logic l2_cp13_trap;
        logic l2_mon_trap;
        logic l3_present;
        logic l3_mon_trap;
    } trap_ctrl_t;

    typedef struct packed {
        logic trap;
        lvl_e target;
    } trap_dec_t;

    typedef struct packed {
        logic [3:0] coproc;
        logic [2:0] opc1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] opc2;
    } acc_enc_t;

    localparam logic [3:0] ENC_COPROC   = 4'hF;
    localparam logic [2:0] ENC_OPC1     = 3'b000;
    localparam logic [3:0] ENC_CRN      = 4'hD;
    localparam logic [2:0] ENC_CRM_HIGH = 3'b011;
    localparam int         IDX_W        = 4;
    localparam int         SYN_W        = 6;
    localparam logic [SYN_W-1:0] SYN_TRAP = 6'h03;

    // Fixed event numbers of the architected event-type registers.
    function automatic logic [15:0] event_code(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd0:    return 16'h0011;
            4'd1:    return 16'h4004;
            4'd2:    return 16'h0008;
            4'd3:    return 16'h4005;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/mon_acc_decode.sv
module mon_acc_decode
    import mon_acc_pkg::*;
(
    input  acc_enc_t              enc,
    output logic                  enc_ok,
    output logic [IDX_W-1:0]      idx
);
    always_comb begin
        enc_ok = (enc.coproc == ENC_COPROC) &&
                 (enc.opc1   == ENC_OPC1)   &&
                 (enc.crn    == ENC_CRN)    &&
                 (enc.crm[3:1] == ENC_CRM_HIGH);
        idx    = {enc.crm[0], enc.opc2};
    end
endmodule

// File: rtl/mon_acc_trap_chain.sv
module mon_acc_trap_chain
    import mon_acc_pkg::*;
(
    input  lvl_e       level,
    input  trap_ctrl_t ctrl,
    output trap_dec_t  dec
);
    logic l2_cp13_hit;
    logic l2_mon_hit;
    logic l3_mon_hit;
    logic host_skip;

    always_comb begin
        host_skip   = ctrl.l2_en && ctrl.l2_host && ctrl.l2_tge;
        l2_cp13_hit = ctrl.l2_en && ctrl.l2_cp13_trap;
        l2_mon_hit  = ctrl.l2_en && ctrl.l2_mon_trap;
        l3_mon_hit  = ctrl.l3_present && ctrl.l3_mon_trap;

        dec.trap   = 1'b0;
        dec.target = LVL1;
        unique case (level)
            LVL0: begin
                if (!ctrl.user_en) begin
                    dec.trap   = 1'b1;
                    dec.target = (ctrl.l2_en && ctrl.l2_tge) ? LVL2 : LVL1;
                end else if (l2_cp13_hit && !host_skip) begin
                    dec.trap   = 1'b1;
                    dec.target = LVL2;
                end else if (l2_mon_hit) begin
                    dec.trap   = 1'b1;
                    dec.target = LVL2;
                end else if (l3_mon_hit) begin
                    dec.trap   = 1'b1;
                    dec.target = LVL3;
                end
            end
            LVL1: begin
                if (l2_cp13_hit || l2_mon_hit) begin
                    dec.trap   = 1'b1;
                    dec.target = LVL2;
                end else if (l3_mon_hit) begin
                    dec.trap   = 1'b1;
                    dec.target = LVL3;
                end
            end
            LVL2: begin
                if (l3_mon_hit) begin
                    dec.trap   = 1'b1;
                    dec.target = LVL3;
                end
            end
            default: begin
                dec.trap   = 1'b0;
                dec.target = LVL1;
            end
        endcase
    end
endmodule

// File: rtl/mon_acc_router.sv
module mon_acc_router
    import mon_acc_pkg::*;
#(
    parameter int ARCH_CNT = 4,
    parameter int DATA_W   = 32,
    parameter int EVT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_coproc,
    input  logic [2:0]        req_opc1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_opc2,
    input  logic [1:0]        cur_level,
    input  logic              user_en,
    input  logic              l2_en,
    input  logic              l2_tge,
    input  logic              l2_host,
    input  logic              l2_cp13_trap,
    input  logic              l2_mon_trap,
    input  logic              l3_present,
    input  logic              l3_mon_trap,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_trap,
    output logic [1:0]        rsp_trap_level,
    output logic [SYN_W-1:0]  rsp_syndrome,
    output logic              rsp_undef
);
    localparam int PAD_W = DATA_W - EVT_W;

    acc_enc_t         enc;
    trap_ctrl_t       ctrl;
    trap_dec_t        dec;
    logic             enc_ok;
    logic [IDX_W-1:0] idx;
    logic             in_range;

    logic              n_trap;
    logic              n_undef;
    logic [DATA_W-1:0] n_rdata;

    assign enc  = '{coproc: req_coproc, opc1: req_opc1, crn: req_crn,
                    crm: req_crm, opc2: req_opc2};
    assign ctrl = '{user_en: user_en, l2_en: l2_en, l2_tge: l2_tge,
                    l2_host: l2_host, l2_cp13_trap: l2_cp13_trap,
                    l2_mon_trap: l2_mon_trap, l3_present: l3_present,
                    l3_mon_trap: l3_mon_trap};

    mon_acc_decode u_decode (
        .enc    (enc),
        .enc_ok (enc_ok),
        .idx    (idx)
    );

    mon_acc_trap_chain u_chain (
        .level (lvl_e'(cur_level)),
        .ctrl  (ctrl),
        .dec   (dec)
    );

    always_comb begin
        in_range = (32'(idx) < 32'(ARCH_CNT));
        n_undef  = !enc_ok;
        n_trap   = enc_ok && dec.trap;
        if (n_undef || n_trap || req_write || !in_range)
            n_rdata = '0;
        else
            n_rdata = {{PAD_W{1'b0}}, EVT_W'(event_code(idx))};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_rdata      <= '0;
            rsp_trap       <= 1'b0;
            rsp_trap_level <= '0;
            rsp_syndrome   <= '0;
            rsp_undef      <= 1'b0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_rdata      <= req_valid ? n_rdata : '0;
            rsp_trap       <= req_valid && n_trap;
            rsp_trap_level <= (req_valid && n_trap) ? 2'(dec.target) : 2'd0;
            rsp_syndrome   <= (req_valid && n_trap) ? SYN_TRAP : '0;
            rsp_undef      <= req_valid && n_undef;
        end
    end

    // R9: trap and undefined are exclusive, and a trap carries no data
    a_r9_trap_undef_excl: assert property (@(posedge clk) disable iff (rst)
        !(rsp_trap && rsp_undef));
    a_r9_trap_zero_data: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> (rsp_rdata == '0));
    // R8: syndrome code follows the trap flag
    a_r8_syndrome_on_trap: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> (rsp_syndrome == SYN_TRAP));
    a_r8_syndrome_clear: assert property (@(posedge clk) disable iff (rst)
        !rsp_trap |-> (rsp_syndrome == '0));
    // R1: an undefined response returns nothing
    a_r1_undef_no_data: assert property (@(posedge clk) disable iff (rst)
        rsp_undef |-> (rsp_rdata == '0));
    // R11: one-cycle response latency
    a_r11_latency: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid)));
    // R7: accesses at level 3 never trap
    a_r7_level3_no_trap: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid) && $past(cur_level) == 2'd3) |-> !rsp_trap);
    // R10: writes never return data
    a_r10_write_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid) && $past(req_write)) |-> (rsp_rdata == '0));

endmodule

// File: tb/mon_acc_router_bench.sv
module mon_acc_router_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        req_valid, req_write;
    logic [3:0]  req_coproc, req_crn, req_crm;
    logic [2:0]  req_opc1, req_opc2;
    logic [1:0]  cur_level;
    logic        user_en, l2_en, l2_tge, l2_host, l2_cp13_trap, l2_mon_trap;
    logic        l3_present, l3_mon_trap;
    logic        rsp_valid, rsp_trap, rsp_undef;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_trap_level;
    logic [5:0]  rsp_syndrome;

    int checks = 0;
    int fails  = 0;

    mon_acc_router u_mon_acc_router (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_coproc(req_coproc), .req_opc1(req_opc1), .req_crn(req_crn),
        .req_crm(req_crm), .req_opc2(req_opc2), .cur_level(cur_level),
        .user_en(user_en), .l2_en(l2_en), .l2_tge(l2_tge), .l2_host(l2_host),
        .l2_cp13_trap(l2_cp13_trap), .l2_mon_trap(l2_mon_trap),
        .l3_present(l3_present), .l3_mon_trap(l3_mon_trap),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap),
        .rsp_trap_level(rsp_trap_level), .rsp_syndrome(rsp_syndrome),
        .rsp_undef(rsp_undef)
    );

    typedef struct {
        logic        v;
        logic        undef;
        logic        trap;
        logic [1:0]  lvl;
        logic [5:0]  syn;
        logic [31:0] data;
    } exp_t;

    // Behavioural reference model from the requirements.
    function automatic exp_t model();
        exp_t e;
        int   lv;
        int   idx;
        int   codes[4] = '{32'h11, 32'h4004, 32'h8, 32'h4005};
        e = '{v: req_valid, undef: 0, trap: 0, lvl: 0, syn: 0, data: 0};
        if (!req_valid) return e;
        if (!(req_coproc == 4'hF && req_opc1 == 3'd0 && req_crn == 4'hD &&
              req_crm[3:1] == 3'b011)) begin
            e.undef = 1;
            return e;
        end
        lv = int'(cur_level);
        if (lv == 0 && !user_en) begin
            e.trap = 1; e.lvl = (l2_en && l2_tge) ? 2'd2 : 2'd1;
        end else if (lv <= 1) begin
            if (l2_en && l2_cp13_trap && !(lv == 0 && l2_host && l2_tge)) begin
                e.trap = 1; e.lvl = 2;
            end else if (l2_en && l2_mon_trap) begin
                e.trap = 1; e.lvl = 2;
            end else if (l3_present && l3_mon_trap) begin
                e.trap = 1; e.lvl = 3;
            end
        end else if (lv == 2 && l3_present && l3_mon_trap) begin
            e.trap = 1; e.lvl = 3;
        end
        if (e.trap) begin
            e.syn = 6'h03;
            return e;
        end
        idx = int'(req_crm[0]) * 8 + int'(req_opc2);
        if (!req_write && idx < 4) e.data = codes[idx];
        return e;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(exp_t e, string tag);
        chk(tag == "" ? "R11" : tag, "valid", 32'(rsp_valid), 32'(e.v));
        chk(tag == "" ? "R1"  : tag, "undef", 32'(rsp_undef), 32'(e.undef));
        chk(tag == "" ? "R4"  : tag, "trap",  32'(rsp_trap),  32'(e.trap));
        chk(tag == "" ? "R5"  : tag, "level", 32'(rsp_trap_level), 32'(e.lvl));
        chk(tag == "" ? "R8"  : tag, "syndrome", 32'(rsp_syndrome), 32'(e.syn));
        chk(tag == "" ? "R2"  : tag, "rdata", rsp_rdata, e.data);
    endtask

    // Inputs are set at a falling edge; the response is sampled one clock later.
    task automatic run(string tag);
        exp_t e;
        e = model();
        @(negedge clk);
        compare(e, tag);
    endtask

    task automatic set_ctrl(logic [7:0] b);
        {user_en, l2_en, l2_tge, l2_host, l2_cp13_trap, l2_mon_trap,
         l3_present, l3_mon_trap} = b;
    endtask

    task automatic good(int idx, int lv, bit wr);
        req_valid = 1; req_write = wr;
        req_coproc = 4'hF; req_opc1 = 3'd0; req_crn = 4'hD;
        req_crm = {3'b011, 1'(idx >> 3)}; req_opc2 = 3'(idx);
        cur_level = 2'(lv);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1;
        good(1, 3, 0);
        set_ctrl(8'h80);
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "valid in reset", 32'(rsp_valid), 0);
        chk("R11", "rdata in reset", rsp_rdata, 0);
        chk("R11", "trap in reset", 32'(rsp_trap), 0);
        rst = 0;
        req_valid = 0;
        run("R11");

        // R2: each event number
        set_ctrl(8'b1000_0000);
        for (int i = 0; i < 4; i++) begin good(i, 0, 0); run("R2"); end
        good(2, 3, 0); chk("R2", "index 2 direct", 32'h8, 32'h8); run("R2");

        // R3: out-of-range indices
        good(4, 1, 0); run("R3");
        good(15, 0, 0); run("R3");
        set_ctrl(8'b1100_0100); good(9, 1, 0); run("R3");

        // R1: bad encodings
        set_ctrl(8'b1000_0000);
        good(0, 0, 0); req_coproc = 4'hE; run("R1");
        good(0, 2, 0); req_crn = 4'hC;    run("R1");
        good(0, 3, 0); req_crm = 4'b0101; run("R1");
        good(0, 1, 0); req_opc1 = 3'd1;   run("R1");

        // R4: user-enable clear at level 0
        set_ctrl(8'b0110_0000); good(0, 0, 0); run("R4");
        set_ctrl(8'b0100_0000); good(0, 0, 0); run("R4");
        set_ctrl(8'b0010_0000); good(0, 0, 0); run("R4");

        // R5: check order at levels 0 and 1
        set_ctrl(8'b1100_1111); good(1, 1, 0); run("R5");
        set_ctrl(8'b1100_0111); good(1, 1, 0); run("R5");
        set_ctrl(8'b1000_1111); good(1, 1, 0); run("R5");
        set_ctrl(8'b1000_0011); good(1, 0, 0); run("R5");
        set_ctrl(8'b1000_0010); good(1, 0, 0); run("R5");

        // R6: host-mode skip at level 0 only
        set_ctrl(8'b1111_1000); good(0, 0, 0); run("R6");
        set_ctrl(8'b1101_1000); good(0, 0, 0); run("R6");
        set_ctrl(8'b1111_1000); good(0, 1, 0); run("R6");

        // R7: levels 2 and 3
        set_ctrl(8'b0111_1111); good(3, 2, 0); run("R7");
        set_ctrl(8'b0111_1101); good(3, 2, 0); run("R7");
        set_ctrl(8'b0111_1111); good(3, 3, 0); run("R7");

        // R9: bad encoding with every trap bit set, and trap with zero data
        set_ctrl(8'b0111_1111); good(0, 0, 0); req_coproc = 4'h0; run("R9");
        set_ctrl(8'b0111_1111); good(0, 0, 0); run("R9");

        // R10: writes return zero and leave contents unchanged
        set_ctrl(8'b1000_0000); good(1, 0, 1); run("R10");
        good(1, 0, 0); run("R10");
        set_ctrl(8'b1000_0001); good(1, 2, 1); run("R10");

        // Random requests, compared every clock against the model
        for (int n = 0; n < 400; n++) begin
            req_valid = 1'($urandom_range(0, 3) != 0);
            req_write = 1'($urandom_range(0, 3) == 0);
            good(int'($urandom_range(0, 15)), int'($urandom_range(0, 3)), req_write);
            req_valid = 1'($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 4) == 0) req_crn = 4'($urandom);
            set_ctrl(8'($urandom));
            run("");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule